// File: doc/BRIEF.md
# Serial-Loaded Looping Pattern Sequencer

This block generates a set of parallel control signals for a device under test by replaying a stored table of rows. After reset it waits for a pattern image on a serial receive line. Bytes are grouped into rows and written into an on-chip RAM at successive addresses, starting at address 0. When the last address has been written, the block switches to playback. It reads one row per clock, steps through every address and returns to address 0 after the last one. It keeps doing this until it is reset or restarted.

Each output bit comes from a fixed bit of the current row, and all bits change on the same clock edge. The block decodes nothing. A level that must last N clock periods is stored as N identical rows. The depth of the RAM therefore sets both the time step and the longest sequence. A synchronous restart input returns the block to loading so that a new image can be sent.

Top module: `seq_pattern_player`

## Requirements
- R1: The receive line idles high and carries 8N1 frames with the least significant bit first. Each bit lasts 16*OS_DIV clocks, and the line is sampled near the middle of each bit.
- R2: A low pulse on an idle line that has ended by the middle of the start bit is treated as noise. It produces no byte.
- R3: A frame whose stop bit is sampled low is discarded. The receiver ignores the line until it goes high again.
- R4: Every WIDTH/8 accepted bytes form one row, with the first byte in bits WIDTH-1..WIDTH-8. A row is written only when its last byte arrives. Rows go to addresses 0, 1, 2, and so on.
- R5: `ctrl_o` is all zeros from reset until playback begins.
- R6: Playback begins on the clock after the last address is written. Row k is on `ctrl_o` for exactly one cycle, k+1 cycles after that start, and the rows follow one per clock.
- R7: After row DEPTH-1 the next cycle shows row 0 again, and playback repeats indefinitely.
- R8: Bytes received during playback do not change the stored rows.
- R9: While `restart_i` is high at a clock edge, `ctrl_o` becomes zero after that edge, and the block returns to loading at address 0. Any partly assembled row is dropped.
- R10: An asynchronous active-low reset, released synchronously, clears all state and sets `ctrl_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous return to loading |
| rx_i | input | 1 | Serial receive line, idle high |
| ctrl_o | output | WIDTH | Parallel control outputs, one per row bit |

## Verification
The serial input is driven in whole bit periods of 16*OS_DIV clocks. The bench never counts cycles from the last stop bit. Instead, while the final frame is being sent, it waits for the first non-zero output and requires that value to be row 0. From then on it samples on every falling edge and expects row (k mod DEPTH) exactly k cycles later. Any missing, extra or shifted row then appears as a mismatch on that very cycle. A restart raised just after one falling edge must show zero output by the next falling edge, one register stage later. The zero output is then checked for a stretch of cycles while the line is quiet.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  typedef enum logic {
    PH_LOAD,
    PH_PLAY
  } phase_e;
endpackage

// File: rtl/seq_uart_rx.sv
module seq_uart_rx import seq_pkg::*; #(
  parameter int OS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  localparam int DW = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;

  logic [1:0]  sync_q;
  rx_state_e   state_q, state_d;
  logic [DW-1:0] div_q, div_d;
  logic [3:0]  os_q, os_d;
  logic [2:0]  bit_q, bit_d;
  logic [7:0]  sh_q, sh_d;
  logic        valid_q, valid_d;
  logic        rx, tick;

  assign rx   = sync_q[1];
  assign tick = (div_q == DW'(OS_DIV - 1));

  always_comb begin
    state_d = state_q;
    div_d   = tick ? '0 : div_q + 1'b1;
    os_d    = os_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    case (state_q)
      RX_IDLE: begin
        div_d = '0;
        os_d  = '0;
        if (!rx) state_d = RX_START;
      end
      RX_START: if (tick) begin
        os_d = os_q + 4'd1;
        if (os_q == 4'd7) begin
          os_d  = '0;
          bit_d = '0;
          state_d = rx ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: if (tick) begin
        os_d = os_q + 4'd1;
        if (os_q == 4'd15) begin
          sh_d  = {rx, sh_q[7:1]};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) state_d = RX_STOP;
        end
      end
      RX_STOP: if (tick) begin
        os_d = os_q + 4'd1;
        if (os_q == 4'd15) begin
          valid_d = rx;
          state_d = rx ? RX_IDLE : RX_BREAK;
        end
      end
      RX_BREAK: if (rx) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      div_q   <= '0;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      state_q <= state_d;
      div_q   <= div_d;
      os_q    <= os_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
    end
  end

  assign byte_o  = sh_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/seq_row_packer.sv
module seq_row_packer #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             accept_i,
  input  logic             clear_i,
  output logic [WIDTH-1:0] word_o,
  output logic             we_o
);
  localparam int BYTES = WIDTH / 8;
  localparam int CW    = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [WIDTH-9:0]   acc_q, acc_d;
  logic               take, last;

  assign word_o = {acc_q, byte_i};
  assign take   = valid_i && accept_i && !clear_i;
  assign last   = (cnt_q == CW'(BYTES - 1));
  assign we_o   = take && last;

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (take) begin
      acc_d = word_o[WIDTH-9:0];
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take || clear_i) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen import seq_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic                     restart_i,
  output logic [$clog2(DEPTH)-1:0] addr_o,
  output logic                     play_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  phase_e        phase_q, phase_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          en;

  assign en = restart_i || we_i || (phase_q == PH_PLAY);

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    if (restart_i) begin
      phase_d = PH_LOAD;
      addr_d  = '0;
    end else if (phase_q == PH_LOAD) begin
      if (we_i) begin
        if (addr_q == LAST) begin
          phase_d = PH_PLAY;
          addr_d  = '0;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
    end else begin
      addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      addr_q  <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
    end
  end

  assign addr_o = addr_q;
  assign play_o = (phase_q == PH_PLAY);
endmodule

// File: rtl/seq_row_ram.sv
module seq_row_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic                     we_i,
  input  logic [WIDTH-1:0]         wdata_i,
  input  logic                     rd_en_i,
  output logic [WIDTH-1:0]         q_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= rd_en_i ? mem[addr_i] : '0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/seq_pattern_player.sv
module seq_pattern_player #(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 16,
  parameter int OS_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             rx_i,
  output logic [WIDTH-1:0] ctrl_o
);
  localparam int AW = $clog2(DEPTH);

  logic             rst_meta_q, rst_n_s;
  logic [7:0]       rx_byte;
  logic             rx_valid;
  logic [WIDTH-1:0] row_word;
  logic             ram_we;
  logic [AW-1:0]    addr;
  logic             play;
  logic             rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  seq_uart_rx #(.OS_DIV(OS_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .rx_i(rx_i),
    .byte_o(rx_byte), .valid_o(rx_valid)
  );

  seq_row_packer #(.WIDTH(WIDTH)) u_pack (
    .clk(clk), .rst_n(rst_n_s), .byte_i(rx_byte), .valid_i(rx_valid),
    .accept_i(!play), .clear_i(restart_i),
    .word_o(row_word), .we_o(ram_we)
  );

  seq_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .we_i(ram_we), .restart_i(restart_i),
    .addr_o(addr), .play_o(play)
  );

  assign rd_en = play && !restart_i;

  seq_row_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n_s), .addr_i(addr), .we_i(ram_we),
    .wdata_i(row_word), .rd_en_i(rd_en), .q_o(ctrl_o)
  );
endmodule

// File: rtl/seq_player_chk.sv
module seq_player_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     restart_i,
  input logic [WIDTH-1:0]         ctrl_o,
  input logic                     play,
  input logic [$clog2(DEPTH)-1:0] addr,
  input logic                     we,
  input logic                     byte_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R3
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !play |-> ctrl_o == '0);

  // R6
  play_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play && !restart_i && addr != LAST) |=> addr == $past(addr) + 1'b1);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play && !restart_i && addr == LAST) |=> (play && addr == '0));

  // R8
  no_play_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !play);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!play && addr == '0 && ctrl_o == '0));
endmodule

bind seq_pattern_player seq_player_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .restart_i(restart_i), .ctrl_o(ctrl_o),
  .play(play), .addr(addr), .we(ram_we), .byte_valid(rx_valid)
);

// File: tb/seq_pattern_player_tb.sv
module seq_pattern_player_tb;
  localparam int WIDTH  = 32;
  localparam int DEPTH  = 16;
  localparam int OS_DIV = 4;
  localparam int BIT    = 16 * OS_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic rx = 1'b1;
  logic [WIDTH-1:0] ctrl;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seq_pattern_player #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OS_DIV(OS_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .rx_i(rx), .ctrl_o(ctrl)
  );

  function automatic logic [31:0] row_of(int k, int seed);
    return {8'(k + 1), 8'(seed * 17), 8'(k * 37 + seed), 8'(8'hC3 ^ 8'(k))};
  endfunction

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [7:0] b, logic stop_bit);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop_bit;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_row(logic [31:0] r);
    for (int j = 3; j >= 0; j--) send_frame(r[j*8 +: 8], 1'b1);
  endtask

  // R1 R2 R3 R4 R5 R6: load a pattern, injecting noise mid-row when asked
  task automatic load_pattern(int seed, bit inject);
    logic [WIDTH-1:0] first;
    logic [31:0] r;
    first = '0;
    for (int k = 0; k < DEPTH; k++) begin
      r = row_of(k, seed);
      for (int j = 3; j >= 0; j--) begin
        if (inject && k == 1 && j == 2) begin
          rx = 1'b0;
          repeat (2 * OS_DIV) @(negedge clk);
          rx = 1'b1;
          repeat (BIT) @(negedge clk);
          send_frame(8'h5A, 1'b0);
        end
        if (k == DEPTH - 1 && j == 0) begin
          check("R5", ctrl, '0);
          fork
            send_frame(r[7:0], 1'b1);
            begin
              for (int w = 0; w < 20 * BIT && first == '0; w++) begin
                @(negedge clk);
                first = ctrl;
              end
            end
          join
        end else begin
          send_frame(r[j*8 +: 8], 1'b1);
        end
      end
    end
    // R6 first non-zero output is row 0
    check("R6", first, row_of(0, seed));
  endtask

  // R6 R7 R4: lock onto row 0 then expect one row per cycle across wraps
  task automatic check_play(int seed, int n, string req);
    int w;
    w = 0;
    while (ctrl !== row_of(0, seed) && w < 4 * DEPTH) begin
      @(negedge clk);
      w++;
    end
    check(req, ctrl, row_of(0, seed));
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      check(req, ctrl, row_of(i % DEPTH, seed));
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10
    check("R10", ctrl, '0);
  endtask

  task automatic t_first_load;
    load_pattern(1, 1'b1);
    check_play(1, 3 * DEPTH + 2, "R7");
  endtask

  task automatic t_ignore_in_play;
    for (int i = 0; i < 5; i++) send_frame(8'(8'h11 * i + 8'h0F), 1'b1);
    // R8 stored rows unchanged
    check_play(1, 2 * DEPTH, "R8");
  endtask

  task automatic t_restart;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    // R9 zero one edge after restart
    check("R9", ctrl, '0);
    repeat (100) @(negedge clk);
    check("R9", ctrl, '0);
    for (int i = 0; i < 3; i++) send_frame(8'hE7, 1'b1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    load_pattern(2, 1'b0);
    // R4 R9 partial row discarded, new pattern aligned
    check_play(2, 2 * DEPTH + 1, "R4");
  endtask

  initial begin
    t_reset();
    t_first_load();
    t_ignore_in_play();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule